// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column index sequence for one read or write burst inside an open SDRAM row. A new access loads a starting column, a burst length code, a burst ordering bit (sequential or interleaved), a direction bit and the write single-location bit. From then on the block presents one column per clock while its enable input is high. The sequence is confined to an aligned block whose size equals the burst length, so the upper column bits never change within a fixed-length burst.

A full-page setting walks the whole row from the start column, wrapping past the top of the row, until a stop request arrives. The final beat of a fixed-length burst is flagged so that a command sequencer or memory model can close the access. A stop request ends the burst after the beat presented in the same cycle. A new start request replaces a running burst. The output stage is combinational from the registered burst state, so the first column appears in the cycle after the start request.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid_o and last_o are low until a start request is accepted.
- R2: A start request sampled on a clock edge makes col_o equal start_col_i in the following cycle, with col_valid_o high when en_i is high.
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats; last_o is high on the final beat only, and col_valid_o is low in the cycle after it.
- R4: With the ordering bit low, the low log2(length) column bits step up by one per beat modulo the length, and all higher column bits keep the start column's value.
- R5: With the ordering bit high, the low log2(length) bits of beat k equal the start column's low bits XOR k, with the higher bits unchanged.
- R6: With a burst length of 1, the ordering bit has no effect: exactly the start column is issued.
- R7: Length code 7 selects full page: columns step up from the start column, wrap from 255 to 0, last_o never rises, the ordering bit is ignored, and the burst continues until stopped.
- R8: When single_wr_i is high, a write access (is_write_i high) issues exactly one beat whatever the length code, while a read still uses the programmed length; with single_wr_i low a write uses the programmed length.
- R9: A stop request with no start in the same cycle lets the beat presented in that cycle be the last one; col_valid_o is low from the next cycle on.
- R10: A start request during a running burst abandons it; the next cycle presents the new start column and the new sequence follows.
- R11: While en_i is low, col_valid_o is low and the burst does not advance; when en_i returns high the same column is presented again.
- R12: The unused length codes 4, 5 and 6 behave as a burst length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst with the access fields below |
| start_col_i | input | 8 | Starting column of the burst |
| bl_code_i | input | 3 | Length code: 0/1/2/3 = 1/2/4/8 beats, 7 = full page, others = 1 beat |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| is_write_i | input | 1 | Access is a write |
| single_wr_i | input | 1 | Writes are single-location accesses |
| stop_i | input | 1 | Terminate the running burst |
| en_i | input | 1 | Issue a beat this cycle; low holds the burst |
| col_valid_o | output | 1 | col_o carries an issued column this cycle |
| col_o | output | 8 | Column index of the current beat |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The properties assume that the access fields are only meaningful in the cycle start_i is high and that stop_i and start_i are ordinary synchronous pulses, with start taking priority when both are high. They also take for granted that a stalled burst keeps its column because nothing but start, stop and en_i moves the state. The directed stimulus changes every input on the falling clock edge, raises start_i for exactly one cycle per access, and checks outputs on the following falling edge, so each presented beat is observed once, including beats around stall, stop and restart cycles.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    parameter int COL_W          = 8;
    parameter int CODE_W         = 3;
    parameter int MAX_FIXED_LOG2 = 3;

    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] cnt;
    } colgen_state_t;

endpackage

// File: rtl/colgen_len_decode.sv
// Turns a length code plus the write override into a wrap mask.
module colgen_len_decode #(
    parameter int COL_W    = 8,
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 3
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              is_write_i,
    input  logic              single_wr_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o
);

    localparam logic [CODE_W-1:0] CODE_FULL = '1;

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        if (code_i == CODE_FULL) begin
            mask_o = '1;
            full_o = 1'b1;
        end else if (int'(code_i) <= MAX_LOG2) begin
            mask_o = (COL_W'(1) << code_i) - COL_W'(1);
        end
        // single-location writes override any programmed length
        if (is_write_i && single_wr_i) begin
            mask_o = '0;
            full_o = 1'b0;
        end
    end

endmodule

// File: rtl/colgen_col_calc.sv
// Forms the column of a beat: masked bits move, the rest come from the base.
module colgen_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_w;
    logic [COL_W-1:0] xor_w;
    logic [COL_W-1:0] moved_w;

    assign seq_w   = base_i + cnt_i;
    assign xor_w   = base_i ^ cnt_i;
    assign moved_w = ilv_i ? xor_w : seq_w;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? moved_w[b] : base_i[b];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              interleave_i,
    input  logic              is_write_i,
    input  logic              single_wr_i,
    input  logic              stop_i,
    input  logic              en_i,
    output logic              col_valid_o,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o
);

    colgen_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             at_end;

    colgen_len_decode #(
        .COL_W    (COL_W),
        .CODE_W   (CODE_W),
        .MAX_LOG2 (MAX_FIXED_LOG2)
    ) u_decode (
        .code_i      (bl_code_i),
        .is_write_i  (is_write_i),
        .single_wr_i (single_wr_i),
        .mask_o      (dec_mask),
        .full_o      (dec_full)
    );

    colgen_col_calc #(
        .COL_W (COL_W)
    ) u_calc (
        .base_i (st_q.base),
        .cnt_i  (st_q.cnt),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_o)
    );

    assign at_end      = !st_q.full && (st_q.cnt == st_q.mask);
    assign col_valid_o = st_q.active && en_i;
    assign last_o      = col_valid_o && at_end;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.mask   = dec_mask;
            st_d.full   = dec_full;
            st_d.ilv    = interleave_i && !dec_full;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (stop_i) begin
                st_d.active = 1'b0;
            end else if (en_i) begin
                if (at_end) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk
    import colgen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] bl_code_i,
    input logic              is_write_i,
    input logic              single_wr_i,
    input logic              stop_i,
    input logic              en_i,
    input logic              col_valid_o,
    input logic [COL_W-1:0]  col_o,
    input logic              last_o
);

    // Independent record of the accepted access, for block-alignment checks.
    logic [COL_W-1:0] cap_col;
    logic [COL_W-1:0] cap_blk;
    logic             cap_full;
    logic [COL_W-1:0] blk_now;
    logic             full_now;

    always_comb begin
        blk_now  = '0;
        full_now = 1'b0;
        case (bl_code_i)
            3'd1:    blk_now = COL_W'(1);
            3'd2:    blk_now = COL_W'(3);
            3'd3:    blk_now = COL_W'(7);
            3'd7:    begin blk_now = '1; full_now = 1'b1; end
            default: blk_now = '0;
        endcase
        if (is_write_i && single_wr_i) begin
            blk_now  = '0;
            full_now = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_col  <= '0;
            cap_blk  <= '0;
            cap_full <= 1'b0;
        end else if (start_i) begin
            cap_col  <= start_col_i;
            cap_blk  <= blk_now;
            cap_full <= full_now;
        end
    end

    a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> col_valid_o);

    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(start_col_i)));

    a_r3_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !col_valid_o);

    a_r4_block_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> (((col_o ^ cap_col) & ~cap_blk) == '0));

    a_r7_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !cap_full);

    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && is_write_i && single_wr_i) |=> (col_valid_o |-> last_o));

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !col_valid_o);

    a_r11_hold_col: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !start_i && !stop_i) |=> $stable(col_o));

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .bl_code_i   (bl_code_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .stop_i      (stop_i),
    .en_i        (en_i),
    .col_valid_o (col_valid_o),
    .col_o       (col_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       en_i = 1'b1;
    logic       col_valid_o;
    logic [7:0] col_o;
    logic       last_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen u_sdram_burst_colgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl_code_i   (bl_code_i),
        .interleave_i(interleave_i),
        .is_write_i  (is_write_i),
        .single_wr_i (single_wr_i),
        .stop_i      (stop_i),
        .en_i        (en_i),
        .col_valid_o (col_valid_o),
        .col_o       (col_o),
        .last_o      (last_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_col(input int s, input int len, input bit ilv, input int k);
        int m;
        int lo;
        if (len == 256) return (s + k) % 256;
        m  = len - 1;
        lo = ilv ? ((s ^ k) & m) : ((s + k) & m);
        return (s & ~m & 255) | lo;
    endfunction

    // issue a start at the current falling edge; returns at the next one
    task automatic launch(input int s, input int code, input bit ilv, input bit wr, input bit swm);
        start_i      = 1'b1;
        start_col_i  = 8'(s);
        bl_code_i    = 3'(code);
        interleave_i = ilv;
        is_write_i   = wr;
        single_wr_i  = swm;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_burst(input string req, input int s, input int code, input bit ilv,
                             input bit wr, input bit swm, input int len);
        launch(s, code, ilv, wr, swm);
        for (int k = 0; k < len; k++) begin
            chk(req, "valid", int'(col_valid_o), 1);
            chk(req, "col", int'(col_o), model_col(s, len, ilv, k));
            chk(req, "last", int'(last_o), (k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk(req, "valid after end", int'(col_valid_o), 0);
    endtask

    task automatic t_reset();
        chk("R1", "valid in reset", int'(col_valid_o), 0);
        chk("R1", "last in reset", int'(last_o), 0);
    endtask

    task automatic t_lengths();
        run_burst("R3", 8'h37, 0, 1'b0, 1'b0, 1'b0, 1);
        run_burst("R3", 8'h37, 1, 1'b0, 1'b0, 1'b0, 2);
        run_burst("R3", 8'h37, 2, 1'b0, 1'b0, 1'b0, 4);
        run_burst("R4", 8'h5D, 3, 1'b0, 1'b0, 1'b0, 8);
        run_burst("R4", 8'hFE, 2, 1'b0, 1'b0, 1'b0, 4);
    endtask

    task automatic t_interleave();
        run_burst("R5", 8'h5D, 3, 1'b1, 1'b0, 1'b0, 8);
        run_burst("R5", 8'h36, 2, 1'b1, 1'b0, 1'b0, 4);
        run_burst("R5", 8'h81, 1, 1'b1, 1'b0, 1'b0, 2);
    endtask

    task automatic t_len_one();
        run_burst("R6", 8'hC9, 0, 1'b1, 1'b0, 1'b0, 1);
        run_burst("R12", 8'h44, 5, 1'b0, 1'b0, 1'b0, 1);
        run_burst("R12", 8'h45, 4, 1'b1, 1'b0, 1'b0, 1);
        run_burst("R12", 8'h46, 6, 1'b0, 1'b1, 1'b0, 1);
    endtask

    task automatic t_write_mode();
        run_burst("R8", 8'h13, 3, 1'b0, 1'b1, 1'b1, 1);
        run_burst("R8", 8'h13, 7, 1'b0, 1'b1, 1'b1, 1);
        run_burst("R8", 8'h13, 3, 1'b0, 1'b0, 1'b1, 8);
        run_burst("R8", 8'h13, 2, 1'b1, 1'b1, 1'b0, 4);
    endtask

    task automatic t_full_page();
        launch(8'hFC, 7, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) begin
            chk("R7", "valid", int'(col_valid_o), 1);
            chk("R7", "col", int'(col_o), (8'hFC + k) % 256);
            chk("R7", "last", int'(last_o), 0);
            if (k == 6) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk("R9", "valid after stop", int'(col_valid_o), 0);
        @(negedge clk);
        chk("R9", "still idle", int'(col_valid_o), 0);
    endtask

    task automatic t_stop_fixed();
        launch(8'h20, 3, 1'b0, 1'b0, 1'b0);
        chk("R9", "beat0", int'(col_o), 8'h20);
        @(negedge clk);
        chk("R9", "beat1", int'(col_o), 8'h21);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9", "valid after stop", int'(col_valid_o), 0);
    endtask

    task automatic t_restart();
        launch(8'h10, 3, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            chk("R10", "old col", int'(col_o), 8'h10 + k);
            if (k < 2) @(negedge clk);
        end
        launch(8'hA2, 2, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk("R10", "valid", int'(col_valid_o), 1);
            chk("R10", "new col", int'(col_o), model_col(8'hA2, 4, 1'b0, k));
            chk("R10", "last", int'(last_o), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10", "valid after end", int'(col_valid_o), 0);
    endtask

    task automatic t_hold();
        launch(8'h42, 2, 1'b0, 1'b0, 1'b0);
        chk("R2", "first col", int'(col_o), 8'h42);
        chk("R2", "first valid", int'(col_valid_o), 1);
        @(negedge clk);
        chk("R11", "beat1", int'(col_o), 8'h43);
        en_i = 1'b0;
        #1;
        chk("R11", "valid while held", int'(col_valid_o), 0);
        @(negedge clk);
        chk("R11", "valid still held", int'(col_valid_o), 0);
        chk("R11", "last while held", int'(last_o), 0);
        @(negedge clk);
        en_i = 1'b1;
        #1;
        chk("R11", "resume valid", int'(col_valid_o), 1);
        chk("R11", "resume col", int'(col_o), 8'h43);
        @(negedge clk);
        chk("R11", "beat2", int'(col_o), 8'h40);
        @(negedge clk);
        chk("R11", "beat3", int'(col_o), 8'h41);
        chk("R11", "beat3 last", int'(last_o), 1);
        @(negedge clk);
        chk("R11", "done", int'(col_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_interleave();
        t_len_one();
        t_write_mode();
        t_full_page();
        t_stop_fixed();
        t_restart();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule